// File: doc/BRIEF.md
# Mouse Motion Packet Encoder

This block turns one pointing-device event into a five-byte serial packet and pushes those bytes, one per transfer, into a downstream byte queue. Each event carries a signed horizontal motion, a signed vertical motion and the state of three buttons. The encoder saturates both motion values to one signed byte and inverts the vertical axis. It builds a header byte in which a pressed button is shown by a cleared bit. It then streams the packet to the queue whenever the queue signals that it has room.

An event is offered with `evt_valid` and is taken in the cycle where `evt_ready` is also high. One event can wait in a holding slot while the previous packet is still being sent. Packets therefore follow each other without interleaving, and back-to-back events leave no idle cycle between packets.

Top module: `mouse_pkt_enc`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `push_valid` is 0 and `evt_ready` is 1.
- R2: The first byte of every packet is a header: bits 7..3 are `10000`. Bit 2 is 0 when `evt_btn[2]` (left) is 1, bit 1 is 0 when `evt_btn[1]` (middle) is 1, and bit 0 is 0 when `evt_btn[0]` (right) is 1. With no button pressed the header is 0x87.
- R3: The second byte is `evt_dx` (16-bit two's complement) saturated to the range -127..+127 and sent as 8-bit two's complement, so it is never 0x80.
- R4: The third byte is the negation of `evt_dy`, saturated to -127..+127 in the same way. The negation is done before saturation, so -32768 gives +127 (0x7F).
- R5: The fourth and fifth bytes of every packet are 0x00.
- R6: The bytes leave in the order header, X, Y, 0, 0. A byte moves only in a cycle where `push_valid` and `push_ready` are both 1. While `push_valid` is 1 and `push_ready` is 0, `push_valid` stays 1 and `push_data` holds its value.
- R7: One event can wait while a packet is in flight. When the slot is full, `evt_ready` is 0, and an `evt_valid` pulse in that state is ignored and produces no packet. A taken event fills the slot in the next cycle.
- R8: While `push_ready` stays 1, the five bytes of a packet go out on five consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Holding slot free; the event is taken when both are 1 |
| evt_dx | input | 16 | Signed horizontal motion |
| evt_dy | input | 16 | Signed vertical motion |
| evt_btn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| push_valid | output | 1 | Packet byte present |
| push_data | output | 8 | Packet byte |
| push_ready | input | 1 | Downstream queue has room |

## Verification
The bench drives motion values exactly at ±127, just past them, and at the 16-bit extremes. A design that wrapped instead of saturating would send a small or sign-flipped byte there. A design that saturated dy before negating it would send 0x80 or overflow on -32768. All eight button combinations are swept, which catches a swapped or non-inverted header bit. Events are also offered while the queue stalls, and an extra pulse is sent while the slot is full. A design that dropped the waiting event, interleaved packets, or took the extra pulse would leave the byte scoreboard short or long.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int BYTE_W    = 8;
  localparam int PKT_BYTES = 5;
  localparam int NUM_BTN   = 3;
  localparam int MOT_W     = 16;
  localparam int IDX_W     = $clog2(PKT_BYTES);
  // header with every button released: top bit set, button bits high
  localparam logic [BYTE_W-1:0] HDR_IDLE =
    BYTE_W'((1 << (BYTE_W - 1)) | ((1 << NUM_BTN) - 1));

  typedef logic [BYTE_W-1:0] pbyte_t;
  typedef pbyte_t [PKT_BYTES-1:0] pkt_t;
endpackage

// File: rtl/mpe_clamp.sv
module mpe_clamp #(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 8,
  parameter bit NEGATE = 1'b0
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int EXT_W = IN_W + 1;
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] val;

  // one extra bit so that negating the most negative input cannot overflow
  assign ext = $signed({din[IN_W-1], din});

  generate
    if (NEGATE) begin : g_neg
      assign val = -ext;
    end else begin : g_pos
      assign val = ext;
    end
  endgenerate

  always_comb begin
    if (val > POS_LIM)      dout = POS_LIM[OUT_W-1:0];
    else if (val < NEG_LIM) dout = NEG_LIM[OUT_W-1:0];
    else                    dout = val[OUT_W-1:0];
  end
endmodule

// File: rtl/mpe_hdr.sv
module mpe_hdr
  import mpe_pkg::*;
(
  input  logic [NUM_BTN-1:0] btn,
  output pbyte_t             hdr
);
  generate
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      if (b < NUM_BTN) begin : g_btn
        assign hdr[b] = HDR_IDLE[b] & ~btn[b];
      end else begin : g_fix
        assign hdr[b] = HDR_IDLE[b];
      end
    end
  endgenerate
endmodule

// File: rtl/mpe_slot.sv
module mpe_slot
  import mpe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  pkt_t in_pkt,
  output logic out_valid,
  output pkt_t out_pkt,
  input  logic out_take
);
  logic full;
  pkt_t held;

  assign in_ready  = ~full;
  assign out_valid = full;
  assign out_pkt   = held;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      held <= '0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      held <= in_pkt;
    end else if (out_take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/mpe_seq.sv
module mpe_seq
  import mpe_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load_valid,
  input  pkt_t   load_pkt,
  output logic   load_take,
  output logic   push_valid,
  output pbyte_t push_data,
  input  logic   push_ready
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_BYTES - 1);

  logic             busy;
  logic [IDX_W-1:0] idx;
  pkt_t             cur;
  logic             fire;
  logic             last;

  assign fire      = busy && push_ready;
  assign last      = (idx == LAST);
  assign load_take = load_valid && (!busy || (fire && last));
  assign push_valid = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      idx       <= '0;
      cur       <= '0;
      push_data <= '0;
    end else if (load_take) begin
      busy      <= 1'b1;
      idx       <= '0;
      cur       <= load_pkt;
      push_data <= load_pkt[0];
    end else if (fire) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        idx       <= idx + 1'b1;
        push_data <= cur[idx + 1'b1];
      end
    end
  end
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_valid,
  output logic               evt_ready,
  input  logic [MOT_W-1:0]   evt_dx,
  input  logic [MOT_W-1:0]   evt_dy,
  input  logic [NUM_BTN-1:0] evt_btn,
  output logic               push_valid,
  output logic [BYTE_W-1:0]  push_data,
  input  logic               push_ready
);
  pbyte_t hdr_b, x_b, y_b;
  pkt_t   new_pkt, wait_pkt;
  logic   wait_valid, wait_take;

  mpe_hdr i_hdr (.btn(evt_btn), .hdr(hdr_b));

  mpe_clamp #(.IN_W(MOT_W), .OUT_W(BYTE_W), .NEGATE(1'b0)) i_clx (
    .din(evt_dx), .dout(x_b));

  mpe_clamp #(.IN_W(MOT_W), .OUT_W(BYTE_W), .NEGATE(1'b1)) i_cly (
    .din(evt_dy), .dout(y_b));

  assign new_pkt[0] = hdr_b;
  assign new_pkt[1] = x_b;
  assign new_pkt[2] = y_b;
  generate
    for (genvar k = 3; k < PKT_BYTES; k++) begin : g_pad
      assign new_pkt[k] = '0;
    end
  endgenerate

  mpe_slot i_slot (
    .clk(clk), .rst(rst),
    .in_valid(evt_valid), .in_ready(evt_ready), .in_pkt(new_pkt),
    .out_valid(wait_valid), .out_pkt(wait_pkt), .out_take(wait_take));

  mpe_seq i_seq (
    .clk(clk), .rst(rst),
    .load_valid(wait_valid), .load_pkt(wait_pkt), .load_take(wait_take),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready));
endmodule

// File: rtl/mpe_chk.sv
module mpe_chk
  import mpe_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic              push_valid,
  input logic [BYTE_W-1:0] push_data,
  input logic              push_ready
);
  logic [IDX_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else if (push_valid && push_ready)
      pos <= (pos == IDX_W'(PKT_BYTES - 1)) ? '0 : pos + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !push_valid && evt_ready);
  // R2
  header_form_chk: assert property (@(posedge clk) disable iff (rst)
    push_valid && pos == '0 |-> push_data[BYTE_W-1:NUM_BTN] == HDR_IDLE[BYTE_W-1:NUM_BTN]);
  // R3
  x_range_chk: assert property (@(posedge clk) disable iff (rst)
    push_valid && pos == IDX_W'(1) |-> push_data != 8'h80);
  // R4
  y_range_chk: assert property (@(posedge clk) disable iff (rst)
    push_valid && pos == IDX_W'(2) |-> push_data != 8'h80);
  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    push_valid && pos >= IDX_W'(3) |-> push_data == '0);
  // R6
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    push_valid && !push_ready |=> push_valid && $stable(push_data));
  // R7
  slot_fill_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid && evt_ready |=> !evt_ready);
  // R8
  stream_chk: assert property (@(posedge clk) disable iff (rst)
    push_valid && push_ready && pos != IDX_W'(PKT_BYTES - 1) |=> push_valid);
endmodule

bind mouse_pkt_enc mpe_chk i_chk (
  .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready));

// File: tb/test_mouse_pkt_enc.sv
`timescale 1ns/1ps
module test_mouse_pkt_enc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [15:0] evt_dx = '0;
  logic [15:0] evt_dy = '0;
  logic [2:0]  evt_btn = '0;
  logic        push_valid;
  logic [7:0]  push_data;
  logic        push_ready = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit stream_mode = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mouse_pkt_enc i_mouse_pkt_enc (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_dx(evt_dx), .evt_dy(evt_dy), .evt_btn(evt_btn),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready));

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sat(int v);
    if (v > 127) return 8'h7f;
    if (v < -127) return 8'h81;
    return 8'(v);
  endfunction

  // driver: offer one event, record its five expected bytes
  task automatic send(int dx, int dy, logic [2:0] btn);
    @(posedge clk); #1;
    while (!evt_ready) begin @(posedge clk); #1; end
    evt_valid = 1'b1; evt_dx = 16'(dx); evt_dy = 16'(dy); evt_btn = btn;
    exp_q.push_back(8'h87 ^ {5'b0, btn}); tag_q.push_back("R2 header");
    exp_q.push_back(sat(dx));             tag_q.push_back("R3 x byte");
    exp_q.push_back(sat(-dy));            tag_q.push_back("R4 y byte");
    exp_q.push_back(8'h00);               tag_q.push_back("R5 pad");
    exp_q.push_back(8'h00);               tag_q.push_back("R5 pad");
    @(posedge clk); #1;
    evt_valid = 1'b0;
  endtask

  // monitor: scoreboard compare, stall hold (R6), streaming (R8)
  bit   prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  int   pos = 0;
  int   last_cyc = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        check(push_valid && push_data == prev_data, "R6 hold under stall",
              {push_valid, push_data}, {1'b1, prev_data});
      end
      if (push_valid && push_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected byte", push_data, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(push_data == e, t, push_data, e);
        end
        if (stream_mode && pos != 0)
          check(cyc - last_cyc == 1, "R8 consecutive bytes", cyc - last_cyc, 1);
        last_cyc = cyc;
        pos = (pos == 4) ? 0 : pos + 1;
      end
      prev_stall = push_valid && !push_ready;
      prev_data  = push_data;
    end
  end

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(posedge clk); n++; end
    repeat (10) @(posedge clk);
    check(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(!push_valid && evt_ready, "R1 during reset", {push_valid, evt_ready}, 2'b01);
    rst = 1'b0;
    @(posedge clk); #1;
    check(!push_valid && evt_ready, "R1 after reset", {push_valid, evt_ready}, 2'b01);

    // streaming with the queue always ready
    push_ready = 1'b1;
    stream_mode = 1'b1;
    for (int b = 0; b < 8; b++) send(b * 3 - 9, 7 - b * 2, 3'(b)); // R2 every combination
    send(127, -127, 3'b000);     // R3 R4 exactly at the limit
    send(128, -128, 3'b101);     // just past the limit
    send(-127, 127, 3'b010);
    send(-128, 128, 3'b111);
    send(-32768, -32768, 3'b100); // R4 negation before saturation
    send(32767, 32767, 3'b001);
    send(0, 0, 3'b000);
    drain();
    stream_mode = 1'b0;

    // R7 holding slot: stall the queue, fill the slot, pulse an extra event
    push_ready = 1'b0;
    send(10, 20, 3'b100);
    send(-30, -40, 3'b011);
    repeat (3) @(posedge clk);
    #1;
    check(!evt_ready, "R7 slot full while stalled", evt_ready, 0);
    evt_valid = 1'b1; evt_dx = 16'd99; evt_dy = 16'd99; evt_btn = 3'b111;
    @(posedge clk); #1;
    evt_valid = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(push_valid, "R6 byte presented while stalled", push_valid, 1);
    // irregular ready pattern
    for (int i = 0; i < 200; i++) begin
      push_ready = (i % 3) != 0;
      @(posedge clk); #1;
    end
    push_ready = 1'b1;
    drain();

    // back-to-back events under a toggling queue
    fork
      begin
        for (int i = 0; i < 6; i++) send(i * 50 - 140, 140 - i * 60, 3'(i));
      end
      begin
        for (int i = 0; i < 150; i++) begin
          push_ready = (i % 4) != 1;
          @(posedge clk); #1;
        end
        push_ready = 1'b1;
      end
    join
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule